// File: doc/BRIEF.md
# Mode-Aware PWM Gate Driver

This block generates the two gate signals for one synchronous buck power stage from a digital duty word. A phase counter runs a fixed-length switching frame. Inside each frame the high-side gate is on first and the low-side gate is on second. A guard interval of a fixed number of clocks, with both gates low, separates every change from one gate to the other. The frame length comes from a configuration word. In standby the frame is half as long, so the stage switches at twice the run frequency. In off mode both gates are held low.

A current comparator output feeds the block. It is only considered while the high-side gate is on and after a blanking interval from that gate's turn-on. It is only considered in run mode. A qualified trip latches a fault that holds both gates low until an external clear arrives. Duty, frame length and mode are taken only at frame boundaries, so a frame in progress is never reshaped.

Top module: `mode_pwm_gate_drv`

## Requirements
- R1: In run mode (mode = 2'b01) the frame lasts L = max(2*DEAD+2, period_cfg) clocks, measured between successive rising edges of the same gate.
- R2: In standby mode (mode = 2'b10) the frame lasts L = max(2*DEAD+2, floor(period_cfg/2)) clocks.
- R3: Within a frame with phase k = 0..L-1, gate_hi is high for DEAD <= k < E and gate_lo is high for E+DEAD <= k < L. E is duty_cmd clamped to the range [DEAD, L-DEAD]. So gate_hi is high for E-DEAD clocks and gate_lo for L-E-DEAD clocks.
- R4: With duty_cmd <= DEAD, gate_hi stays low for the whole frame. With duty_cmd >= L-DEAD, gate_lo stays low for the whole frame. The guard gaps are still kept.
- R5: gate_hi and gate_lo are never high together. Before every rising edge of either gate, both gates have been low for at least DEAD clocks.
- R6: duty_cmd, period_cfg and mode are latched only at a frame start. A change in the middle of a frame leaves the rest of that frame unchanged.
- R7: Mode 2'b00 or 2'b11 is off: both gates are low from the cycle after the clock edge that sees it. Leaving off starts a fresh frame.
- R8: oc_cmp is ignored unless gate_hi is high and the phase is at least DEAD+BLANK, so it is ignored during the first BLANK clocks of each high-side pulse, during the low-side pulse and during the guard gaps.
- R9: A qualified oc_cmp in run mode sets oc_fault on that clock edge. While oc_fault is set both gates are low, and oc_fault stays set until fault_clr.
- R10: While mode is standby, oc_cmp never sets oc_fault, and switching continues.
- R11: A clock edge with fault_clr high clears oc_fault, and switching restarts with a fresh frame.
- R12: During reset both gates and oc_fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| mode | input | 2 | 00 off, 01 run, 10 standby, 11 off |
| period_cfg | input | CNT_W | Run-mode frame length in clocks |
| duty_cmd | input | CNT_W | Phase at which the high-side gate turns off |
| oc_cmp | input | 1 | Overcurrent comparator output, high means trip |
| fault_clr | input | 1 | Clears the latched fault |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| oc_fault | output | 1 | Latched overcurrent fault |

## Verification
A corrupted phase counter or latched frame length shows up within one frame as a wrong rising-edge spacing on the gates. A wrong latched edge shows as wrong pulse widths. Both are measured directly at the outputs for every duty value of a short frame and a spread of duty values of the longest frame. A broken blanking or mode qualifier shows on the next clock edge as an oc_fault that should not rise, or one that fails to rise. Its stickiness and the forced-low gates are observed for a hundred cycles before the clear is applied.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RUN  = 2'b01,
    MODE_STBY = 2'b10,
    MODE_HALT = 2'b11
  } drv_mode_e;

  // Frame length: halved in standby, never shorter than min_len.
  function automatic int frame_len(input int cfg, input bit half, input int min_len);
    int base;
    base = half ? (cfg >> 1) : cfg;
    return (base < min_len) ? min_len : base;
  endfunction

  // Turn-off phase of the high side, kept where both guard gaps fit.
  function automatic int edge_pos(input int duty, input int len, input int dead);
    if (duty < dead) return dead;
    if (duty > len - dead) return len - dead;
    return duty;
  endfunction

endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEAD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  drv_mode_e        mode_in,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] duty_cmd,
  output logic [CNT_W-1:0] phase_q,
  output logic [CNT_W-1:0] edge_q,
  output logic [CNT_W-1:0] len_q,
  output logic             active_q,
  output drv_mode_e        mode_q
);

  localparam int LMIN = 2 * DEAD + 2;

  logic             frame_wrap;
  logic [CNT_W-1:0] next_len;
  logic [CNT_W-1:0] next_edge;

  assign frame_wrap = !active_q || (phase_q == len_q - 1'b1);
  assign next_len   = CNT_W'(frame_len(int'(period_cfg), mode_in == MODE_STBY, LMIN));
  assign next_edge  = CNT_W'(edge_pos(int'(duty_cmd), int'(next_len), DEAD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      active_q <= 1'b0;
      len_q    <= CNT_W'(LMIN);
      edge_q   <= CNT_W'(DEAD);
      mode_q   <= MODE_OFF;
    end else if (!run_ok) begin
      phase_q  <= '0;
      active_q <= 1'b0;
    end else if (frame_wrap) begin
      phase_q  <= '0;
      active_q <= 1'b1;
      len_q    <= next_len;
      edge_q   <= next_edge;
      mode_q   <= mode_in;
    end else begin
      phase_q  <= phase_q + 1'b1;
    end
  end

  AST_PHASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (phase_q < len_q)); // R1

  AST_FRAME_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && (phase_q != '0)) |-> ($stable(edge_q) && $stable(len_q))); // R6

endmodule

// File: rtl/pwm_gate_decode.sv
module pwm_gate_decode #(
  parameter int CNT_W = 8,
  parameter int DEAD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] phase_q,
  input  logic [CNT_W-1:0] edge_q,
  input  logic             active_q,
  input  logic             fault_q,
  output logic             gate_hi,
  output logic             gate_lo
);

  logic             drive_en;
  logic [CNT_W:0]   lo_start;

  assign drive_en = active_q && !fault_q;
  assign lo_start = {1'b0, edge_q} + (CNT_W+1)'(DEAD);
  assign gate_hi  = drive_en && (int'(phase_q) >= DEAD) && (phase_q < edge_q);
  assign gate_lo  = drive_en && ({1'b0, phase_q} >= lo_start);

  // Consecutive cycles with both gates low, saturating.
  logic [7:0] both_low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) both_low_cnt <= '0;
    else if (gate_hi || gate_lo) both_low_cnt <= '0;
    else if (both_low_cnt != 8'hFF) both_low_cnt <= both_low_cnt + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R5

  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (int'(both_low_cnt) >= DEAD)); // R5

endmodule

// File: rtl/pwm_oc_guard.sv
module pwm_oc_guard #(
  parameter int CNT_W = 8,
  parameter int DEAD  = 4,
  parameter int BLANK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_hi,
  input  logic [CNT_W-1:0] phase_q,
  input  logic             run_now,
  input  logic             run_latched,
  input  logic             oc_cmp,
  input  logic             fault_clr,
  output logic             fault_q
);

  logic oc_window;
  logic oc_hit;

  assign oc_window = gate_hi && run_now && run_latched && (int'(phase_q) >= DEAD + BLANK);
  assign oc_hit    = oc_window && oc_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (oc_hit)    fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  // Length of the current high-side pulse so far, saturating.
  logic [7:0] hi_age;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_age <= '0;
    else if (!gate_hi) hi_age <= '0;
    else if (hi_age != 8'hFF) hi_age <= hi_age + 1'b1;
  end

  AST_BLANK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> ($past(gate_hi) && (int'($past(hi_age)) >= BLANK))); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q); // R9

  AST_STBY_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_now && !fault_q) |=> !fault_q); // R10

endmodule

// File: rtl/mode_pwm_gate_drv.sv
module mode_pwm_gate_drv
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DEAD  = 4,
  parameter int BLANK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             oc_cmp,
  input  logic             fault_clr,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             oc_fault
);

  drv_mode_e        mode_e;
  drv_mode_e        mode_q;
  logic             switching_mode;
  logic             run_ok;
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] edge_q;
  logic [CNT_W-1:0] len_q;
  logic             active_q;

  assign mode_e         = drv_mode_e'(mode);
  assign switching_mode = (mode_e == MODE_RUN) || (mode_e == MODE_STBY);
  assign run_ok         = switching_mode && !oc_fault;

  pwm_phase_ctr #(.CNT_W(CNT_W), .DEAD(DEAD)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_ok     (run_ok),
    .mode_in    (mode_e),
    .period_cfg (period_cfg),
    .duty_cmd   (duty_cmd),
    .phase_q    (phase_q),
    .edge_q     (edge_q),
    .len_q      (len_q),
    .active_q   (active_q),
    .mode_q     (mode_q)
  );

  pwm_gate_decode #(.CNT_W(CNT_W), .DEAD(DEAD)) dec_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_q  (phase_q),
    .edge_q   (edge_q),
    .active_q (active_q),
    .fault_q  (oc_fault),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
  );

  pwm_oc_guard #(.CNT_W(CNT_W), .DEAD(DEAD), .BLANK(BLANK)) oc_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_hi     (gate_hi),
    .phase_q     (phase_q),
    .run_now     (mode_e == MODE_RUN),
    .run_latched (mode_q == MODE_RUN),
    .oc_cmp      (oc_cmp),
    .fault_clr   (fault_clr),
    .fault_q     (oc_fault)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !switching_mode |=> (!gate_hi && !gate_lo)); // R7

  AST_FAULT_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> (!gate_hi && !gate_lo)); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!gate_hi && !gate_lo && !oc_fault)); // R12

endmodule

// File: tb/mode_pwm_gate_drv_tb_top.sv
module mode_pwm_gate_drv_tb_top;

  localparam int CNT_W = 8;
  localparam int DEAD  = 4;
  localparam int BLANK = 3;
  localparam int FLOOR = 2 * DEAD + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic [CNT_W-1:0] period_cfg = '0;
  logic [CNT_W-1:0] duty_cmd = '0;
  logic             oc_cmp = 1'b0;
  logic             fault_clr = 1'b0;
  logic             gate_hi;
  logic             gate_lo;
  logic             oc_fault;

  int checks = 0;
  int errors = 0;
  int cur_len = FLOOR;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mode_pwm_gate_drv #(.CNT_W(CNT_W), .DEAD(DEAD), .BLANK(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .period_cfg(period_cfg),
    .duty_cmd(duty_cmd), .oc_cmp(oc_cmp), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .oc_fault(oc_fault)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int want_len(input int p, input bit sb);
    int v;
    v = sb ? p / 2 : p;
    return (v > FLOOR) ? v : FLOOR;
  endfunction

  function automatic int want_edge(input int d, input int l);
    int lo_lim, hi_lim;
    lo_lim = DEAD;
    hi_lim = l - DEAD;
    return (d >= hi_lim) ? hi_lim : ((d <= lo_lim) ? lo_lim : d);
  endfunction

  function automatic logic pick(input bit hi_sel);
    return hi_sel ? gate_hi : gate_lo;
  endfunction

  task automatic apply(input logic [1:0] m, input int p, input int d);
    int nl;
    @(negedge clk);
    mode = m;
    period_cfg = CNT_W'(p);
    duty_cmd = CNT_W'(d);
    nl = want_len(p, m == 2'b10);
    repeat (cur_len + nl + 4) @(negedge clk);
    cur_len = nl;
  endtask

  // Measure one frame from a rising edge of a gate to its next rising edge.
  task automatic measure(input int l, input int e, input string preq, input string wreq);
    bit sel;
    logic prev, cur;
    int t, hc, lc, ov, guard;
    sel = (e - DEAD) > 0;
    prev = pick(sel);
    guard = 0;
    forever begin
      @(negedge clk);
      cur = pick(sel);
      if (!prev && cur) break;
      prev = cur;
      guard++;
      if (guard > 1200) break;
    end
    if (guard > 1200) begin
      chk(1'b0, preq, "no gate edge", 0, 1);
      return;
    end
    t = 0; hc = 0; lc = 0; ov = 0;
    prev = 1'b1;
    guard = 0;
    forever begin
      hc += int'(gate_hi);
      lc += int'(gate_lo);
      ov += int'(gate_hi && gate_lo);
      t++;
      @(negedge clk);
      cur = pick(sel);
      if (!prev && cur) break;
      prev = cur;
      if (t > 1200) break;
    end
    chk(t == l, preq, "frame length", t, l);
    chk(hc == e - DEAD, wreq, "high-side width", hc, e - DEAD);
    chk(lc == l - e - DEAD, wreq, "low-side width", lc, l - e - DEAD);
    chk(ov == 0, "R5", "overlap cycles", ov, 0);
  endtask

  task automatic sweep(input logic [1:0] m, input int p, input int d0, input int d1, input int step);
    int l, e;
    string wr;
    for (int d = d0; d <= d1; d += step) begin
      apply(m, p, d);
      l = want_len(p, m == 2'b10);
      e = want_edge(d, l);
      wr = (d <= DEAD || d >= l - DEAD) ? "R4" : "R3";
      measure(l, e, (m == 2'b10) ? "R2" : "R1", wr);
    end
  endtask

  task automatic wait_hi_rise();
    logic prev;
    prev = gate_hi;
    for (int g = 0; g < 1200; g++) begin
      @(negedge clk);
      if (!prev && gate_hi) return;
      prev = gate_hi;
    end
  endtask

  task automatic wait_lo_rise();
    logic prev;
    prev = gate_lo;
    for (int g = 0; g < 1200; g++) begin
      @(negedge clk);
      if (!prev && gate_lo) return;
      prev = gate_lo;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      report();
    end
  end

  initial begin
    int cnt, w;
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(!gate_hi && !gate_lo, "R12", "gates in reset", int'(gate_hi) + int'(gate_lo), 0);
    chk(!oc_fault, "R12", "fault in reset", int'(oc_fault), 0);
    rst_n = 1'b1;

    // R1/R3/R4: every duty of a short run frame
    sweep(2'b01, 20, 0, 24, 1);
    // R2: standby halves the frame
    sweep(2'b10, 40, 0, 24, 1);
    // Long frames
    sweep(2'b01, 255, 0, 255, 17);
    sweep(2'b10, 255, 0, 130, 10);
    // Floor on the frame length
    sweep(2'b01, 5, 3, 3, 1);
    sweep(2'b10, 0, 100, 100, 1);

    // R6: mid-frame duty change waits for the next frame
    apply(2'b01, 40, 20);
    wait_hi_rise();
    duty_cmd = 8'd30;
    w = 0;
    while (gate_hi && w < 300) begin w++; @(negedge clk); end
    chk(w == 16, "R6", "pulse after mid-frame change", w, 16);
    measure(40, 30, "R6", "R6");

    // R7: off modes hold the gates low
    apply(2'b01, 40, 20);
    @(negedge clk);
    mode = 2'b00;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin cnt += int'(gate_hi) + int'(gate_lo); @(negedge clk); end
    chk(cnt == 0, "R7", "gate highs in mode 00", cnt, 0);
    mode = 2'b11;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin cnt += int'(gate_hi) + int'(gate_lo); @(negedge clk); end
    chk(cnt == 0, "R7", "gate highs in mode 11", cnt, 0);
    mode = 2'b01;
    cur_len = 0;
    measure(40, 20, "R7", "R7");

    // R8: trip inside the blanking window is ignored
    wait_hi_rise();
    oc_cmp = 1'b1;
    repeat (BLANK) @(negedge clk);
    oc_cmp = 1'b0;
    repeat (3) @(negedge clk);
    chk(!oc_fault, "R8", "fault after blanked trip", int'(oc_fault), 0);
    // R8: trip during low side and guard gaps is ignored
    wait_lo_rise();
    oc_cmp = 1'b1;
    repeat (16 + DEAD + BLANK) @(negedge clk);
    oc_cmp = 1'b0;
    repeat (3) @(negedge clk);
    chk(!oc_fault, "R8", "fault after low-side trip", int'(oc_fault), 0);

    // R9: qualified trip latches and forces gates low
    wait_hi_rise();
    repeat (BLANK) @(negedge clk);
    oc_cmp = 1'b1;
    @(negedge clk);
    oc_cmp = 1'b0;
    chk(oc_fault, "R9", "fault after qualified trip", int'(oc_fault), 1);
    chk(!gate_hi && !gate_lo, "R9", "gates with fault", int'(gate_hi) + int'(gate_lo), 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin cnt += int'(gate_hi) + int'(gate_lo); @(negedge clk); end
    chk(cnt == 0, "R9", "gate highs while faulted", cnt, 0);
    chk(oc_fault, "R9", "fault sticky", int'(oc_fault), 1);

    // R11: clear restarts switching
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk(!oc_fault, "R11", "fault after clear", int'(oc_fault), 0);
    measure(40, 20, "R11", "R11");

    // R10: standby ignores the comparator
    apply(2'b10, 80, 20);
    oc_cmp = 1'b1;
    repeat (200) @(negedge clk);
    chk(!oc_fault, "R10", "fault in standby", int'(oc_fault), 0);
    measure(40, 20, "R10", "R10");
    // back to run with the comparator still high: trips again
    mode = 2'b01;
    repeat (200) @(negedge clk);
    chk(oc_fault, "R9", "fault on return to run", int'(oc_fault), 1);
    oc_cmp = 1'b0;
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk(!oc_fault, "R11", "second clear", int'(oc_fault), 0);

    done = 1'b1;
    report();
  end

endmodule